// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller

This block is a four-wire, full-duplex serial peripheral port driven by a small CPU register interface. A role bit in the control word picks its behaviour at run time. In master mode it makes the serial clock by dividing the system clock and drives the select line. In slave mode it samples an external clock, select and data line, all in the system clock domain. One shift register carries both directions: the outgoing character is written into it, and the incoming character builds up in it bit by bit. When a character finishes, it is copied into a separate receive holding register. The next character can therefore start before the CPU has collected the last one.

Characters are 8 or 16 bits long and travel most-significant bit first. The clock idle level and the sampling phase are both programmable. The CPU sees two addresses. Address 0 is the control/status word. Address 1 is the data port: a write loads the shift register, and a read returns the receive holding register. Three flags in the status word report an active transfer, a finished character and a receive overrun.

Top module: `spi_dual_ctrl`

## Requirements
- R1: While the enable bit (control bit 0) is 0, no transfer runs and the busy flag stays 0. The pins rest at sck_o=0, ssel_n_o=1, mosi_o=0 and miso_o=0. A data write in this state starts nothing.
- R2: The role bit (control bit 1) selects the mode: 1 is master, which drives sck_o and ssel_n_o; 0 is slave, which takes sck_i and ssel_n_i. In slave mode ssel_n_o stays 1 and sck_o stays 0.
- R3: The length bit (control bit 4) sets 16-bit characters when 1 and 8-bit characters when 0. With 8-bit characters only the low byte of the shift register moves, and bits 15:8 of the receive holding register read as 0.
- R4: A data-port write (address 1) loads the shift register, and in master mode it starts a transfer. A data-port read returns the receive holding register. A data-port write made while the busy flag is 1 is ignored.
- R5: When a character completes, the received value is copied to the receive holding register and the done flag (status bit 13) is set. A second transfer can run before the first result has been read.
- R6: Transmit and receive are simultaneous, most-significant bit first. With the phase bit (control bit 3) at 0, the first bit is valid as soon as select asserts, and each bit is sampled on the odd-numbered clock edges (1st, 3rd, ...). With the phase bit at 1, a bit is driven on the odd-numbered edges and sampled on the even-numbered edges (2nd, 4th, ...).
- R7: The polarity bit (control bit 2) sets the serial clock idle level: 0 idles low, 1 idles high.
- R8: The divider field (control bits 11:8, value D) gives a serial clock half-period of D+1 system clocks, so the fastest rate is half the system clock. In master mode ssel_n_o goes low in the cycle after the data write and stays low for exactly 2·N·(D+1) cycles, where N is the character length.
- R9: In slave mode the input pins pass through synchronizers. A complete character received from an external master lands in the receive holding register. The slave's own shift register contents go out on miso_o. If select is released in the middle of a character, that character is dropped, the done flag stays as it was, and the next character starts counting from bit 0.
- R10: Status bit 12 is busy. Writing 1 to status bit 13 clears the done flag, and writing 1 to bit 14 clears the overrun flag. The overrun flag (bit 14) is set when a character completes while the previous one is still unread. A data-port read marks the holding register as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = control/status, 1 = data port |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| sck_o | output | 1 | Serial clock driven in master mode |
| ssel_n_o | output | 1 | Active-low select driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | External serial clock for slave mode |
| ssel_n_i | input | 1 | External active-low select for slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
The hardest situation to reach is a slave select released partway through a character. This must leave no trace, and the following character must still line up on bit 0. The bench acts as the external master through its own pin-level task: it drops select, gives three clock edges, releases select, and then runs a full character. A receive overrun is reached in master mode by running two transfers back to back without touching the data port. A write made during a transfer is placed in a slow, long-divider transfer, so the outgoing bit stream on the pins shows whether that write changed anything.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 4;
    localparam int CNT_W  = $clog2(2 * DATA_W + 1);

    // control / status word bit positions
    localparam int B_EN     = 0;
    localparam int B_MASTER = 1;
    localparam int B_CPOL   = 2;
    localparam int B_CPHA   = 3;
    localparam int B_LEN16  = 4;
    localparam int B_DIV    = 8;
    localparam int B_BUSY   = 12;
    localparam int B_DONE   = 13;
    localparam int B_OVR    = 14;

    typedef struct packed {
        logic              en;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic              len16;
        logic [DIV_W-1:0]  div;
        logic              busy;
        logic              done;
        logic              ovr;
        logic              unread;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rxbuf;
        logic              dout;
        logic              sck;
        logic              sck_prev;
        logic [CNT_W-1:0]  cnt;
    } ctl_state_t;

    function automatic logic lead_bit(input logic [DATA_W-1:0] v, input logic l16);
        return l16 ? v[DATA_W-1] : v[BYTE_W-1];
    endfunction
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
    import spi_dual_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_sel,
    input  logic        cpu_wr,
    input  logic        cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        sck_o,
    output logic        ssel_n_o,
    output logic        mosi_o,
    input  logic        miso_i,
    input  logic        sck_i,
    input  logic        ssel_n_i,
    input  logic        mosi_i,
    output logic        miso_o
);
    ctl_state_t d, q;

    logic       s_sck, s_ssel_n, s_mosi;
    logic       tick;
    logic       wr_ctrl, wr_data, rd_data;
    logic       edge_ev, rx_in, sample;
    logic [CNT_W-1:0] last_edge;
    logic [15:0] status;

    // slave inputs: {sck, ssel_n, mosi}; select rests inactive at reset
    spi_sync2 #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_i, ssel_n_i, mosi_i}),
        .dout ({s_sck, s_ssel_n, s_mosi})
    );

    spi_baud #(.W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.en && q.master && q.busy),
        .div  (q.div),
        .tick (tick)
    );

    assign wr_ctrl   = cpu_sel && cpu_wr && !cpu_addr;
    assign wr_data   = cpu_sel && cpu_wr && cpu_addr;
    assign rd_data   = cpu_sel && !cpu_wr && cpu_addr;
    assign last_edge = q.len16 ? CNT_W'(2 * DATA_W) : CNT_W'(2 * BYTE_W);
    assign sample    = (q.cnt[0] == q.cpha);

    always_comb begin
        d          = q;
        d.sck_prev = s_sck;
        edge_ev    = 1'b0;
        rx_in      = 1'b0;

        if (wr_ctrl) begin
            d.en     = cpu_wdata[B_EN];
            d.master = cpu_wdata[B_MASTER];
            d.cpol   = cpu_wdata[B_CPOL];
            d.cpha   = cpu_wdata[B_CPHA];
            d.len16  = cpu_wdata[B_LEN16];
            d.div    = cpu_wdata[B_DIV +: DIV_W];
            if (cpu_wdata[B_DONE]) d.done = 1'b0;
            if (cpu_wdata[B_OVR])  d.ovr  = 1'b0;
        end
        if (rd_data) d.unread = 1'b0;

        if (!q.en) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.sck  = q.cpol;
            if (wr_data) d.sh = cpu_wdata;
            d.dout = lead_bit(d.sh, q.len16);
        end else if (q.master) begin
            rx_in   = miso_i;
            edge_ev = q.busy && tick;
            if (!q.busy) begin
                d.sck = q.cpol;
                d.cnt = '0;
                if (wr_data) begin
                    d.sh   = cpu_wdata;
                    d.busy = 1'b1;
                end
                d.dout = lead_bit(d.sh, q.len16);
            end
        end else begin
            rx_in   = s_mosi;
            edge_ev = !s_ssel_n && (s_sck != q.sck_prev);
            d.sck   = q.cpol;
            if (s_ssel_n) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                if (wr_data && !q.busy) d.sh = cpu_wdata;
                d.dout = lead_bit(d.sh, q.len16);
            end else begin
                d.busy = 1'b1;
            end
        end

        if (edge_ev) begin
            if (q.master) d.sck = ~q.sck;
            if (sample) begin
                if (q.len16) d.sh = {q.sh[DATA_W-2:0], rx_in};
                else         d.sh[BYTE_W-1:0] = {q.sh[BYTE_W-2:0], rx_in};
            end else begin
                d.dout = lead_bit(q.sh, q.len16);
            end
            d.cnt = q.cnt + 1'b1;
            if (d.cnt == last_edge) begin
                d.cnt   = '0;
                d.rxbuf = q.len16 ? d.sh : {{(DATA_W-BYTE_W){1'b0}}, d.sh[BYTE_W-1:0]};
                d.done  = 1'b1;
                if (q.unread && !rd_data) d.ovr = 1'b1;
                d.unread = 1'b1;
                if (q.master) d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status                  = '0;
        status[B_EN]            = q.en;
        status[B_MASTER]        = q.master;
        status[B_CPOL]          = q.cpol;
        status[B_CPHA]          = q.cpha;
        status[B_LEN16]         = q.len16;
        status[B_DIV +: DIV_W]  = q.div;
        status[B_BUSY]          = q.busy;
        status[B_DONE]          = q.done;
        status[B_OVR]           = q.ovr;
    end

    assign cpu_rdata = cpu_addr ? q.rxbuf : status;
    assign sck_o     = (q.en && q.master) ? q.sck : 1'b0;
    assign ssel_n_o  = !(q.en && q.master && q.busy);
    assign mosi_o    = q.en && q.master && q.busy && q.dout;
    assign miso_o    = q.en && !q.master && !s_ssel_n && q.dout;
endmodule

// File: rtl/spi_dual_ctrl_chk.sv
module spi_dual_ctrl_chk
    import spi_dual_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_sel,
    input logic       cpu_wr,
    input logic       cpu_addr,
    input logic       sck_o,
    input logic       ssel_n_o,
    input ctl_state_t st
);
    // R1: a disabled port never reports a transfer in the following cycle
    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !st.en |=> !st.busy);

    // R2: slave role leaves the master-side clock and select at rest
    p_slave_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st.en && !st.master) |-> (ssel_n_o && !sck_o));

    // R8: select only ever asserts right after a data-port write
    p_ssel_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssel_n_o) |-> $past(cpu_sel && cpu_wr && cpu_addr));

    // R7: between transfers the master clock rests at the polarity level
    p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st.en && st.master && $past(st.en && st.master) && ssel_n_o
         && $past(ssel_n_o) && $stable(st.cpol)) |-> (sck_o == st.cpol));

    // R5: a master transfer that ends normally always raises done
    p_done_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st.busy) && st.master && $past(st.master) && st.en && $past(st.en))
        |-> st.done);

    // R10: overrun appears only when an unread character was waiting
    p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.ovr) |-> ($past(st.unread) && st.done));
endmodule

bind spi_dual_ctrl spi_dual_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_sel  (cpu_sel),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .sck_o    (sck_o),
    .ssel_n_o (ssel_n_o),
    .st       (q)
);

// File: tb/spi_dual_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_dual_ctrl_tb_top;
    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        sck_o, ssel_n_o, mosi_o, miso_i, miso_o;
    logic        sck_i = 1'b0, ssel_n_i = 1'b1, mosi_i = 1'b0;

    int n_chk = 0, n_bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    assign miso_i = ~mosi_o;   // inverted loopback for master runs

    spi_dual_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sck_o(sck_o), .ssel_n_o(ssel_n_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .sck_i(sck_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
    );

    // pin monitor for master transfers, sampled at falling clock edges
    logic        mon_cpha = 1'b0;
    logic [15:0] mon_bits;
    int          mon_edges, mon_low, ssel_falls = 0;
    logic        p_low = 1'b0, p_sck = 1'b0, p_mosi = 1'b0;
    always @(negedge clk) begin
        if (!ssel_n_o && !p_low) begin
            mon_bits = '0; mon_edges = 0; mon_low = 0; ssel_falls++;
        end
        if (!ssel_n_o) mon_low++;
        if (p_low && sck_o != p_sck) begin
            if ((mon_edges % 2) == int'(mon_cpha)) mon_bits = {mon_bits[14:0], p_mosi};
            mon_edges++;
        end
        p_low = !ssel_n_o; p_sck = sck_o; p_mosi = mosi_o;
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] v);
        @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        @(negedge clk); cpu_sel = 1; cpu_wr = 0; cpu_addr = a; #1; v = cpu_rdata;
        @(negedge clk); cpu_sel = 0;
    endtask

    function automatic logic [15:0] ctl(input logic en, ms, pol, pha, l16, input logic [3:0] dv);
        return {4'b0, dv, 3'b0, l16, pha, pol, ms, en};
    endfunction

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(1'b0, s);
            if (!s[12]) return;
        end
    endtask

    // bench acting as external master towards the slave port
    task automatic ext_xfer(input logic pol, pha, input int nb, input logic [15:0] tx,
                            input int stop_after, output logic [15:0] cap);
        int bit_i = 0;
        cap = '0;
        @(negedge clk); sck_i = pol;
        if (!pha) mosi_i = tx[nb-1];
        repeat (HP) @(negedge clk);
        ssel_n_i = 0;
        repeat (HP) @(negedge clk);
        for (int e = 0; e < 2 * nb && e < stop_after; e++) begin
            if ((e % 2) == int'(pha)) begin
                cap = {cap[14:0], miso_o};
                sck_i = ~sck_i;
            end else begin
                sck_i = ~sck_i;
                bit_i = pha ? (e / 2) : ((e + 1) / 2);
                if (bit_i < nb) mosi_i = tx[nb-1-bit_i];
            end
            repeat (HP) @(negedge clk);
        end
        ssel_n_i = 1;
        repeat (2 * HP) @(negedge clk);
    endtask

    // {cpol, cpha, len16, div[3:0], tx[15:0]}
    localparam logic [22:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 4'd0, 16'h00A5},
        {1'b0, 1'b1, 1'b0, 4'd1, 16'h003C},
        {1'b1, 1'b0, 1'b0, 4'd2, 16'h0081},
        {1'b1, 1'b1, 1'b1, 4'd0, 16'hBEEF},
        {1'b0, 1'b0, 1'b1, 4'd3, 16'h1234},
        {1'b1, 1'b1, 1'b0, 4'd5, 16'hFF6A}
    };

    initial begin
        logic [15:0] v, cap, r0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        rd(1'b0, v); chk("R1 reset status", v, 16'h0000);
        rd(1'b1, v); chk("R5 reset rx buffer", v, 16'h0000);
        chk("R1 reset pins", {sck_o, ssel_n_o, mosi_o, miso_o}, 4'b0100);

        // disabled: data write starts nothing
        wr(1'b0, ctl(0, 1, 0, 0, 0, 0));
        wr(1'b1, 16'h00A5);
        repeat (50) @(negedge clk);
        chk("R1 no select while disabled", ssel_falls, 0);
        rd(1'b0, v); chk("R1 busy stays 0 while disabled", v[12], 1'b0);

        // master vector table
        foreach (VEC[k]) begin
            logic pol, pha, l16; logic [3:0] dv; logic [15:0] tx, exp_tx;
            int nb;
            {pol, pha, l16, dv, tx} = VEC[k];
            nb = l16 ? 16 : 8;
            exp_tx = l16 ? tx : {8'h00, tx[7:0]};
            wr(1'b0, ctl(1, 1, pol, pha, l16, dv));
            mon_cpha = pha;
            repeat (2) @(negedge clk);
            chk("R7 idle clock level", sck_o, pol);
            wr(1'b1, tx);
            wait_idle();
            chk("R6 bits seen on mosi", mon_bits & (l16 ? 16'hFFFF : 16'h00FF), exp_tx);
            chk("R6 clock edge count", mon_edges, 2 * nb);
            chk("R8 select low duration", mon_low, 2 * nb * (int'(dv) + 1));
            chk("R7 clock back at idle", sck_o, pol);
            rd(1'b0, v); chk("R5 done flag after transfer", v[13], 1'b1);
            rd(1'b1, v); chk("R3 received character", v, ~exp_tx & (l16 ? 16'hFFFF : 16'h00FF));
        end

        // write while busy is ignored
        wr(1'b0, ctl(1, 1, 0, 0, 0, 7));
        mon_cpha = 0;
        wr(1'b1, 16'h005A);
        repeat (10) @(negedge clk);
        wr(1'b1, 16'h00C3);
        wait_idle();
        chk("R4 write during transfer ignored (pins)", mon_bits & 16'h00FF, 16'h005A);
        rd(1'b1, v); chk("R4 write during transfer ignored (rx)", v, 16'h00A5);

        // back-to-back transfers without reading: overrun
        wr(1'b0, ctl(1, 1, 0, 0, 0, 0) | 16'h6000);
        rd(1'b0, v); chk("R10 flags cleared by writing 1", v[14:13], 2'b00);
        wr(1'b1, 16'h0011); wait_idle();
        wr(1'b1, 16'h0022); wait_idle();
        rd(1'b0, v); chk("R10 overrun set", v[14:13], 2'b11);
        rd(1'b1, v); chk("R5 second result held", v, 16'h00DD);
        wr(1'b0, ctl(1, 1, 0, 0, 0, 0) | 16'h6000);
        wr(1'b1, 16'h0033); wait_idle();
        rd(1'b0, v); chk("R10 no overrun after read", v[14:13], 2'b01);
        rd(1'b1, v);

        // slave mode transfers
        begin
            int falls0;
            falls0 = ssel_falls;
            wr(1'b0, ctl(1, 0, 0, 0, 0, 0) | 16'h6000);
            wr(1'b1, 16'h003C);
            ext_xfer(0, 0, 8, 16'h0096, 99, cap);
            chk("R9 slave miso bits", cap & 16'h00FF, 16'h003C);
            rd(1'b1, v); chk("R9 slave received", v, 16'h0096);
            rd(1'b0, v); chk("R10 slave done, not busy", v[13:12], 2'b10);
            chk("R2 master select idle in slave role", ssel_falls, falls0);

            wr(1'b0, ctl(1, 0, 1, 1, 1, 0) | 16'h6000);
            wr(1'b1, 16'hA1B2);
            ext_xfer(1, 1, 16, 16'h4D7E, 99, cap);
            chk("R6 slave phase1 miso", cap, 16'hA1B2);
            rd(1'b1, v); chk("R3 slave 16-bit received", v, 16'h4D7E);

            wr(1'b0, ctl(1, 0, 1, 0, 0, 0) | 16'h6000);
            wr(1'b1, 16'h00C5);
            ext_xfer(1, 0, 8, 16'h001F, 99, cap);
            chk("R7 slave polarity1 miso", cap & 16'h00FF, 16'h00C5);
            rd(1'b1, v); chk("R7 slave polarity1 received", v, 16'h001F);

            // select released mid-character
            wr(1'b0, ctl(1, 0, 0, 0, 0, 0) | 16'h6000);
            rd(1'b1, r0);
            ext_xfer(0, 0, 8, 16'h00FF, 3, cap);
            rd(1'b0, v); chk("R9 aborted character: no done", v[13], 1'b0);
            rd(1'b1, v); chk("R9 aborted character: buffer kept", v, r0);
            wr(1'b1, 16'h0000);
            ext_xfer(0, 0, 8, 16'h005E, 99, cap);
            rd(1'b1, v); chk("R9 next character aligned", v, 16'h005E);
            chk("R2 slave leaves sck_o low", sck_o, 1'b0);
        end

        finish_run();
    end
endmodule